// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between the serial shift engine of an SPI controller and the CPU side. It owns two byte FIFOs, four entries deep: one collects bytes from the shift engine for the CPU, and the other holds bytes that the CPU queues for transmission. From their occupancy and a set of transfer events it builds a 16-bit read-only status word and drives a single interrupt line.

The receive FIFO is drained by the CPU over a valid/ready port. Bytes are offered while `rx_out_valid` is high, and a byte is consumed on any clock edge where both `rx_out_valid` and `rx_out_ready` are high. The transmit FIFO is filled over a valid/ready port. A byte is taken on an edge where both `tx_in_valid` and `tx_in_ready` are high, and `tx_in_ready` stays low while four bytes are held. The shift engine cannot stall, so its two sides are plain strobes. `rx_in_valid` delivers a received byte, and `tx_take` removes the byte at the head of the transmit FIFO. When a byte arrives at a full receive FIFO it is lost, and a take from an empty transmit FIFO returns zero. Both of these are reported as errors.

Software sets four controls: a receive threshold, a direction bit that selects receive or transmit completion as the completion interrupt, and one mask for each of the two error interrupts. Most status flags are sticky and clear when software reads the status word. `stat_rd` marks that read, and the word is valid on `stat_rdata` in the same cycle.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset the status word is 0x0000 and `irq` is 0. `tx_in_ready` is 1 and `rx_out_valid` is 0.
- R2: Status bits 15:12 always read 0. Bits 10:8 give the receive occupancy and bits 3:1 give the transmit occupancy, each as a binary count from 0 to 4.
- R3: Each FIFO delivers bytes in arrival order. `tx_in_ready` is 0 while the transmit FIFO holds 4 bytes, and a write offered at that time is not stored.
- R4: Bit 11 is high exactly while the receive occupancy is greater than `rx_thresh`.
- R5: A byte delivered on `rx_in_valid` while the receive FIFO holds 4 bytes, with no CPU pop in the same cycle, sets bit 7 from the next cycle. That byte is dropped and the stored bytes stay unchanged.
- R6: A `tx_take` while the transmit FIFO is empty presents 0x00 on `tx_byte` and sets bit 4 from the next cycle. The occupancy stays 0.
- R7: With `dir_tx` = 0, an accepted receive byte with no pop in the same cycle that brings the receive occupancy to exactly `rx_thresh` sets bit 6.
- R8: With `dir_tx` = 1, a `tx_take` that removes the last byte of the transmit FIFO, with no CPU write in the same cycle, sets bit 5. With `dir_tx` = 0, bit 5 never sets.
- R9: Bit 0 sets on any event that sets bit 6 or bit 5. It also sets on an event that sets bit 7 while `mask_ovf` is 0, and on an event that sets bit 4 while `mask_unf` is 0.
- R10: A `stat_rd` clears bits 7, 6, 5, 4 and 0 from the next cycle. Bit 11 and both occupancy fields are unaffected.
- R11: When a flag-setting event and `stat_rd` occur in the same cycle, the flag is set after that edge.
- R12: `irq` changes on the same edge as the flags. It is high when bit 6 or bit 5 is set, when bit 7 is set and `mask_ovf` is 0, or when bit 4 is set and `mask_unf` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in_valid | input | 1 | Shift engine delivers a received byte (no back-pressure) |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive FIFO holds a byte for the CPU |
| rx_out_ready | input | 1 | CPU consumes the head byte |
| rx_out_data | output | 8 | Receive FIFO head byte |
| tx_in_valid | input | 1 | CPU offers a byte to transmit |
| tx_in_ready | output | 1 | Transmit FIFO has room |
| tx_in_data | input | 8 | Byte to transmit |
| tx_take | input | 1 | Shift engine starts a byte transfer and removes the head |
| tx_byte | output | 8 | Byte to shift out (0x00 when the FIFO is empty) |
| rx_thresh | input | 3 | Receive threshold, 0 to 4 |
| dir_tx | input | 1 | 1 = transmit completion interrupts, 0 = receive completion |
| mask_ovf | input | 1 | Suppresses the receive-overflow interrupt |
| mask_unf | input | 1 | Suppresses the transmit-underflow interrupt |
| stat_rd | input | 1 | Status word read strobe |
| stat_rdata | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is driven through three threshold patterns. The first stays below the threshold, the second lands exactly on it and the third goes past it. Together they separate the live excess flag from the one-shot completion flag, and show that the direction bit gates completion. The transmit path is filled to capacity, has a write refused, and is drained with tx_take in both direction settings, which tells an ordering fault from a wrong completion condition. The error patterns cover overflow and underflow with masks on and off, and a status read that coincides with an event. These show whether the sticky flags, the summary bit and the interrupt line each follow their own rule.

// File: rtl/spi_fifo_stat_pkg.sv
package spi_fifo_stat_pkg;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int STAT_W = 16;

  // status word positions decoded by software
  localparam int B_EXCESS = 11;
  localparam int B_RXCNT  = 8;
  localparam int B_OVF    = 7;
  localparam int B_RXDONE = 6;
  localparam int B_TXDONE = 5;
  localparam int B_UNF    = 4;
  localparam int B_TXCNT  = 1;
  localparam int B_ANY    = 0;

  typedef struct packed {
    logic ovf;
    logic rxdone;
    logic txdone;
    logic unf;
  } evt_t;

  typedef struct packed {
    logic ovf;
    logic rxdone;
    logic txdone;
    logic unf;
    logic any;
  } flags_t;
endpackage

// File: rtl/sfs_byte_fifo.sv
module sfs_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         wr_ok,
  output logic                         rd_ok
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rd_ok = pop && !empty;
  assign wr_ok = push && (!full || rd_ok);
  assign dout  = mem[rp];

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= adv(wp);
      if (rd_ok) rp <= adv(rp);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfs_flags.sv
module sfs_flags
  import spi_fifo_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  evt_t   evt,
  input  logic   rd,
  input  logic   mask_ovf,
  input  logic   mask_unf,
  output flags_t flags,
  output logic   irq
);
  flags_t nxt;
  logic   fire;

  // an event in the read cycle survives the clear
  assign fire = evt.rxdone | evt.txdone | (evt.ovf & ~mask_ovf) | (evt.unf & ~mask_unf);

  always_comb begin
    nxt.ovf    = evt.ovf    | (flags.ovf    & ~rd);
    nxt.rxdone = evt.rxdone | (flags.rxdone & ~rd);
    nxt.txdone = evt.txdone | (flags.txdone & ~rd);
    nxt.unf    = evt.unf    | (flags.unf    & ~rd);
    nxt.any    = fire       | (flags.any    & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= (nxt.ovf & ~mask_ovf) | (nxt.unf & ~mask_unf) | nxt.rxdone | nxt.txdone;
    end
  end
endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
  import spi_fifo_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  input  logic              tx_take,
  output logic [DATA_W-1:0] tx_byte,
  input  logic [CNT_W-1:0]  rx_thresh,
  input  logic              dir_tx,
  input  logic              mask_ovf,
  input  logic              mask_unf,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              irq
);
  logic [CNT_W-1:0]  rx_cnt, tx_cnt;
  logic              rx_full, rx_empty, rx_wr_ok, rx_rd_ok;
  logic              tx_full, tx_empty, tx_wr_ok, tx_rd_ok;
  logic [DATA_W-1:0] tx_head;
  evt_t              evt;
  flags_t            flags;

  sfs_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(rx_in_valid), .din(rx_in_data),
    .pop(rx_out_ready), .dout(rx_out_data),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .wr_ok(rx_wr_ok), .rd_ok(rx_rd_ok)
  );

  sfs_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .push(tx_in_valid && tx_in_ready), .din(tx_in_data),
    .pop(tx_take), .dout(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .wr_ok(tx_wr_ok), .rd_ok(tx_rd_ok)
  );

  assign rx_out_valid = !rx_empty;
  assign tx_in_ready  = !tx_full;
  assign tx_byte      = tx_empty ? '0 : tx_head;

  always_comb begin
    evt.ovf    = rx_in_valid && rx_full && !rx_rd_ok;
    evt.unf    = tx_take && tx_empty;
    evt.rxdone = !dir_tx && rx_wr_ok && !rx_rd_ok && ((rx_cnt + CNT_W'(1)) == rx_thresh);
    evt.txdone = dir_tx && tx_rd_ok && !tx_wr_ok && (tx_cnt == CNT_W'(1));
  end

  sfs_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd(stat_rd),
    .mask_ovf(mask_ovf), .mask_unf(mask_unf),
    .flags(flags), .irq(irq)
  );

  always_comb begin
    stat_rdata                         = '0;
    stat_rdata[B_EXCESS]               = (rx_cnt > rx_thresh);
    stat_rdata[B_RXCNT +: CNT_W]       = rx_cnt;
    stat_rdata[B_OVF]                  = flags.ovf;
    stat_rdata[B_RXDONE]               = flags.rxdone;
    stat_rdata[B_TXDONE]               = flags.txdone;
    stat_rdata[B_UNF]                  = flags.unf;
    stat_rdata[B_TXCNT +: CNT_W]       = tx_cnt;
    stat_rdata[B_ANY]                  = flags.any;
  end
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import spi_fifo_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_in_valid,
  input logic              rx_out_ready,
  input logic              tx_take,
  input logic [DATA_W-1:0] tx_byte,
  input logic              stat_rd,
  input logic [STAT_W-1:0] stat_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [CNT_W-1:0]  tx_cnt
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH) && tx_cnt <= CNT_W'(DEPTH));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_cnt == CNT_W'(DEPTH) && !rx_out_ready) |=> stat_rdata[B_OVF]);

  assert_zero_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_cnt == '0) |-> tx_byte == '0);

  assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_cnt == '0) |=> stat_rdata[B_UNF]);

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_in_valid && !tx_take) |=>
      (stat_rdata[B_OVF:B_UNF] == '0 && !stat_rdata[B_ANY]));

  assert_done_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[B_RXDONE] || stat_rdata[B_TXDONE]) |-> irq);
endmodule

bind spi_fifo_stat sfs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rx_in_valid(rx_in_valid), .rx_out_ready(rx_out_ready),
  .tx_take(tx_take), .tx_byte(tx_byte), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
  .irq(irq), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt)
);

// File: tb/sim_spi_fifo_stat.sv
module sim_spi_fifo_stat;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_in_valid = 0, rx_out_ready = 0, tx_in_valid = 0, tx_take = 0;
  logic [7:0] rx_in_data = 0, tx_in_data = 0;
  logic [2:0] rx_thresh = 3'd4;
  logic dir_tx = 0, mask_ovf = 0, mask_unf = 0, stat_rd = 0;
  logic rx_out_valid, tx_in_ready, irq;
  logic [7:0] rx_out_data, tx_byte;
  logic [15:0] stat_rdata;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  spi_fifo_stat u0 (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rx_push(input logic [7:0] d);
    rx_in_valid = 1; rx_in_data = d; tick; rx_in_valid = 0;
  endtask
  task automatic tx_push(input logic [7:0] d);
    tx_in_valid = 1; tx_in_data = d; tick; tx_in_valid = 0;
  endtask
  task automatic rd_stat; stat_rd = 1; tick; stat_rd = 0; endtask
  task automatic rx_pop(input string tag, input logic [7:0] d);
    chk(tag, {15'd0, rx_out_valid}, 16'd1);
    chk(tag, {8'd0, rx_out_data}, {8'd0, d});
    rx_out_ready = 1; tick; rx_out_ready = 0;
  endtask
  task automatic tx_pop(input string tag, input logic [7:0] d);
    chk(tag, {8'd0, tx_byte}, {8'd0, d});
    tx_take = 1; tick; tx_take = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", stat_rdata, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 tx ready", {15'd0, tx_in_ready}, 16'd1);
    chk("R1 rx valid", {15'd0, rx_out_valid}, 16'd0);
  endtask

  task automatic t_tx_order;
    dir_tx = 0;
    for (int i = 0; i < 4; i++) tx_push(8'hA1 + 8'(i));
    chk("R2 tx count 4", stat_rdata, 16'h0008);
    chk("R3 tx full ready", {15'd0, tx_in_ready}, 16'd0);
    tx_push(8'hFF);
    chk("R3 refused write", stat_rdata, 16'h0008);
    for (int i = 0; i < 4; i++) tx_pop("R3 tx order", 8'hA1 + 8'(i));
    chk("R8 no tx done with dir 0", stat_rdata, 16'h0000);
  endtask

  task automatic t_excess;
    dir_tx = 1; rx_thresh = 3'd2;
    rx_push(8'h31); rx_push(8'h32);
    chk("R4 at threshold", stat_rdata, 16'h0200);
    rx_push(8'h33);
    chk("R4 above threshold", stat_rdata, 16'h0B00);
    rx_pop("R3 rx order", 8'h31);
    chk("R4 back at threshold", stat_rdata, 16'h0200);
    rx_pop("R3 rx order", 8'h32); rx_pop("R3 rx order", 8'h33);
    chk("R2 rx empty", stat_rdata, 16'h0000);
  endtask

  task automatic t_overflow;
    dir_tx = 1; rx_thresh = 3'd4;
    for (int i = 0; i < 4; i++) rx_push(8'h10 + 8'(i));
    rx_push(8'hEE);
    chk("R5 R9 overflow flags", stat_rdata, 16'h0481);
    chk("R12 overflow irq", {15'd0, irq}, 16'd1);
    rd_stat;
    chk("R10 clear keeps count", stat_rdata, 16'h0400);
    chk("R12 irq drops", {15'd0, irq}, 16'd0);
    for (int i = 0; i < 4; i++) rx_pop("R5 contents kept", 8'h10 + 8'(i));
    chk("R5 dropped byte absent", {15'd0, rx_out_valid}, 16'd0);
  endtask

  task automatic t_underflow;
    tx_pop("R6 zero byte", 8'h00);
    chk("R6 underflow flags", stat_rdata, 16'h0011);
    chk("R12 underflow irq", {15'd0, irq}, 16'd1);
    rd_stat;
    chk("R10 underflow cleared", stat_rdata, 16'h0000);
  endtask

  task automatic t_rxdone;
    dir_tx = 0; rx_thresh = 3'd2;
    rx_push(8'h51);
    chk("R7 below threshold", stat_rdata, 16'h0100);
    rx_push(8'h52);
    chk("R7 rx done", stat_rdata, 16'h0241);
    chk("R12 rx done irq", {15'd0, irq}, 16'd1);
    rd_stat;
    rx_pop("R7 drain", 8'h51); rx_pop("R7 drain", 8'h52);
    chk("R7 pops raise nothing", stat_rdata, 16'h0000);
  endtask

  task automatic t_txdone;
    dir_tx = 1;
    tx_push(8'h61); tx_push(8'h62);
    chk("R2 tx count 2", stat_rdata, 16'h0004);
    tx_pop("R8 first", 8'h61);
    chk("R8 not yet", stat_rdata, 16'h0002);
    tx_pop("R8 last", 8'h62);
    chk("R8 R9 tx done", stat_rdata, 16'h0021);
    chk("R12 tx done irq", {15'd0, irq}, 16'd1);
    rd_stat;
    chk("R10 tx done cleared", stat_rdata, 16'h0000);
  endtask

  task automatic t_setwins;
    stat_rd = 1; tx_take = 1; tick; stat_rd = 0; tx_take = 0;
    chk("R11 set wins", stat_rdata, 16'h0011);
    rd_stat;
    chk("R11 later read clears", stat_rdata, 16'h0000);
  endtask

  task automatic t_mask;
    dir_tx = 1; rx_thresh = 3'd4; mask_ovf = 1; mask_unf = 1;
    for (int i = 0; i < 5; i++) rx_push(8'h70 + 8'(i));
    chk("R9 masked overflow no summary", stat_rdata, 16'h0480);
    chk("R12 masked overflow no irq", {15'd0, irq}, 16'd0);
    rd_stat;
    for (int i = 0; i < 4; i++) rx_pop("R5 masked contents", 8'h70 + 8'(i));
    tx_pop("R6 masked zero byte", 8'h00);
    chk("R9 masked underflow", stat_rdata, 16'h0010);
    chk("R12 masked underflow no irq", {15'd0, irq}, 16'd0);
    rd_stat;
    mask_ovf = 0; mask_unf = 0;
    chk("R10 final clear", stat_rdata, 16'h0000);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run;
  end

  initial begin
    #9 rst_n = 1'b1;
    tick;
    t_reset;
    t_tx_order;
    t_excess;
    t_overflow;
    t_underflow;
    t_rxdone;
    t_txdone;
    t_setwins;
    t_mask;
    finish_run;
  end
endmodule